// File: doc/BRIEF.md
# Eight-Source Prioritised Interrupt Level Controller

This block collects interrupt requests from eight add-on modules and turns them into one 3-bit priority level for a processor. Each request line is active-low at the pins by default. Each line is asynchronous and gets its own synchronizer. Each source has its own 8-bit control/status register on a small synchronous register port.

The register selects the sensing mode (edge or level) and the active polarity. It also holds an enable and a 3-bit priority, where priority 0 silences the source. In edge mode an active transition sets a sticky pending latch. Software clears that latch by writing a one to a clear strobe bit. In level mode the status follows the qualified input directly.

The output carries the highest priority among all sources that are currently signalling. It reads 0 when none are. The register port is plain control access with no handshake: a write is taken in the cycle its strobe is high, and read data appears one cycle after the read strobe. Interrupt acknowledge and vector supply are handled elsewhere.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every source register reads 0x00 and `irq_level` is 0.
- R2: Register layout (address = source index 0..7): bit 7 polarity, bit 6 mode (1 = edge, 0 = level), bit 5 status (read-only), bit 4 enable, bit 3 clear strobe, bits 2:0 priority. Read data is registered and valid the cycle after `reg_rd`. It holds its value when no read is made. The clear bit always reads 0, and writes to bit 5 are ignored.
- R3: In level mode with polarity 0, a source is active while its request pin is low. Its status reads 1 and it contributes its priority to `irq_level`, then stops when the pin returns high.
- R4: Polarity 1 inverts the sense: in level mode a high pin is active and a low pin is inactive.
- R5: In edge mode, an active edge sets a pending latch that stays set after the pin returns to idle. With polarity 0 the active edge is the falling edge, and with polarity 1 it is the rising edge. The opposite edge has no effect.
- R6: Writing a register with bit 3 = 1 clears the pending latch of an edge-mode source. In level mode the same write leaves the status unchanged.
- R7: With enable 0 a source reads status 0 and adds nothing to `irq_level`. An edge captured while disabled becomes visible once the source is enabled.
- R8: A source whose priority is 0 never drives `irq_level` and reads status 0.
- R9: `irq_level` equals the largest priority among sources whose status is 1, or 0 if none.
- R10: If an active edge and a clear write reach the same source in the same cycle, the latch ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_n | input | 8 | Asynchronous request pins, one per source |
| reg_addr | input | 3 | Register select (source index) |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, one cycle after `reg_rd` |
| irq_level | output | 3 | Highest active priority, 0 when idle |

## Verification
A table of level-mode patterns turns sources on and off one at a time. This shows that the output picks the maximum and not the most recent source, and that disabling a source or setting its priority to zero removes it even while its pin is asserted. Directed edge-mode sequences check several things: stickiness after the pin goes idle, that only the chosen edge counts, that clears work in edge mode and do nothing in level mode, and that a latch captured while disabled shows up once enabled. One sequence is timed cycle-exactly so that an edge and a clear write land in the same cycle, which separates set-priority from clear-priority. Readback with a write that sets the status and clear bits shows that those bits are not stored.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_SRC   = 8;
  localparam int PRIO_W    = 3;
  localparam int REG_W     = 8;
  localparam int ADDR_W    = $clog2(NUM_SRC);

  localparam int BIT_POL   = 7;
  localparam int BIT_EDGE  = 6;
  localparam int BIT_STAT  = 5;
  localparam int BIT_EN    = 4;
  localparam int BIT_CLR   = 3;

  typedef struct packed {
    logic              pol;
    logic              edge_mode;
    logic              en;
    logic [PRIO_W-1:0] prio;
  } src_cfg_t;
endpackage

// File: rtl/irqc_source.sv
module irqc_source
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_n,
  input  logic              wr_hit,
  input  logic [REG_W-1:0]  wdata,
  output logic              status,
  output logic [PRIO_W-1:0] prio,
  output logic [REG_W-1:0]  reg_word
);
  src_cfg_t cfg_q;
  logic     sync1_q, sync2_q, prev_q;
  logic     pend_q, pend_d;
  logic     active, edge_evt, clr_hit, next_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      prev_q  <= 1'b1;
    end else begin
      sync1_q <= req_n;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  // pin level qualified by polarity; transitions selected by polarity
  assign active   = cfg_q.pol ? sync2_q : ~sync2_q;
  assign edge_evt = cfg_q.pol ? (sync2_q & ~prev_q) : (~sync2_q & prev_q);

  assign clr_hit   = wr_hit & wdata[BIT_CLR] & cfg_q.edge_mode;
  assign next_edge = wr_hit ? wdata[BIT_EDGE] : cfg_q.edge_mode;

  always_comb begin
    if (!next_edge)
      pend_d = 1'b0;
    else if (cfg_q.edge_mode && edge_evt)
      pend_d = 1'b1;
    else
      pend_d = pend_q & ~clr_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (wr_hit) begin
        cfg_q.pol       <= wdata[BIT_POL];
        cfg_q.edge_mode <= wdata[BIT_EDGE];
        cfg_q.en        <= wdata[BIT_EN];
        cfg_q.prio      <= wdata[PRIO_W-1:0];
      end
    end
  end

  assign status = (cfg_q.edge_mode ? pend_q : active) & cfg_q.en & (cfg_q.prio != '0);
  assign prio   = cfg_q.prio;

  always_comb begin
    reg_word               = '0;
    reg_word[BIT_POL]      = cfg_q.pol;
    reg_word[BIT_EDGE]     = cfg_q.edge_mode;
    reg_word[BIT_STAT]     = status;
    reg_word[BIT_EN]       = cfg_q.en;
    reg_word[PRIO_W-1:0]   = cfg_q.prio;
  end

  // R5
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !wr_hit) |=> pend_q);

  // R6
  level_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.edge_mode |-> !pend_q);

  // R10
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.edge_mode && edge_evt && clr_hit && wdata[BIT_EDGE]) |=> pend_q);
endmodule

// File: rtl/irqc_max_prio.sv
module irqc_max_prio
  import irqc_pkg::*;
#(
  parameter int N = NUM_SRC,
  parameter int W = PRIO_W
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   act,
  input  logic [N*W-1:0] prios,
  output logic [W-1:0]   max_prio
);
  always_comb begin
    max_prio = '0;
    for (int i = 0; i < N; i++) begin
      if (act[i] && prios[i*W +: W] > max_prio)
        max_prio = prios[i*W +: W];
    end
  end

  // R9
  out_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (max_prio != '0) |-> (act != '0));

  generate
    for (genvar g = 0; g < N; g++) begin : g_chk
      // R9
      out_covers_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act[g] |-> (max_prio >= prios[g*W +: W]));
    end
  endgenerate
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] irq_req_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [PRIO_W-1:0] irq_level
);
  logic [NUM_SRC-1:0]        status;
  logic [NUM_SRC*PRIO_W-1:0] prios;
  logic [REG_W-1:0]          words [NUM_SRC];

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      irqc_source u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_n    (irq_req_n[s]),
        .wr_hit   (reg_wr && (reg_addr == ADDR_W'(s))),
        .wdata    (reg_wdata),
        .status   (status[s]),
        .prio     (prios[s*PRIO_W +: PRIO_W]),
        .reg_word (words[s])
      );
    end
  endgenerate

  irqc_max_prio #(.N(NUM_SRC), .W(PRIO_W)) u_max (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (status),
    .prios    (prios),
    .max_prio (irq_level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      reg_rdata <= '0;
    else if (reg_rd)
      reg_rdata <= words[reg_addr];
  end

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_rd) |-> $stable(reg_rdata));

  // R2
  clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[BIT_CLR]);
endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  localparam real HALF = 2.5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_req_n = 8'hFF;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [2:0] irq_level;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(HALF) clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req_n(irq_req_n), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_level(irq_level)
  );

  // {src[2:0], cfg[7:0], req_n[7:0], expected level[2:0]}
  localparam int NV = 8;
  localparam logic [21:0] VEC [NV] = '{
    {3'd0, 8'h13, 8'hFF, 3'd0},  // R3 idle pin
    {3'd0, 8'h13, 8'hFE, 3'd3},  // R3 low pin active
    {3'd5, 8'h16, 8'hDE, 3'd6},  // R9 higher wins
    {3'd5, 8'h06, 8'hDE, 3'd3},  // R7 disabled drops out
    {3'd2, 8'h97, 8'hFE, 3'd7},  // R4 high active with pol 1
    {3'd2, 8'h97, 8'hFA, 3'd3},  // R4 low inactive with pol 1
    {3'd0, 8'h10, 8'hFA, 3'd0},  // R8 priority 0 silent
    {3'd7, 8'h11, 8'h7A, 3'd1}   // R9 single low source
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic do_reset();
    irq_req_n = 8'hFF;
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    do_reset();

    // R1 reset state
    chk("R1 irq_level", {5'd0, irq_level}, 8'h00);
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), d);
      chk("R1 reg", d, 8'h00);
    end

    // R3 R4 R7 R8 R9 table walk
    for (int v = 0; v < NV; v++) begin
      wr(VEC[v][21:19], VEC[v][18:11]);
      irq_req_n = VEC[v][10:3];
      settle();
      chk($sformatf("R9 vec%0d level", v), {5'd0, irq_level}, {5'd0, VEC[v][2:0]});
    end

    // R2 readback: src3 pin high, pol1 level, clear bit set on write
    wr(3'd3, 8'hBD);
    settle();
    rd(3'd3, d);
    chk("R2 readback status set, clr zero", d, 8'hB5);
    wr(3'd3, 8'h20);
    settle();
    rd(3'd3, d);
    chk("R2 status write ignored", d, 8'h00);

    // R5 edge mode, pol 0
    do_reset();
    wr(3'd4, 8'h52);
    settle();
    chk("R5 no edge yet", {5'd0, irq_level}, 8'h00);
    irq_req_n[4] = 1'b0; settle();
    chk("R5 falling edge latched", {5'd0, irq_level}, 8'h02);
    irq_req_n[4] = 1'b1; settle();
    chk("R5 sticky after release", {5'd0, irq_level}, 8'h02);
    rd(3'd4, d);
    chk("R5 status bit", d, 8'h72);
    // R6 clear in edge mode
    wr(3'd4, 8'h5A); settle();
    chk("R6 edge clear", {5'd0, irq_level}, 8'h00);

    // R5 pol 1: falling ignored, rising latches
    wr(3'd1, 8'hD4); settle();
    irq_req_n[1] = 1'b0; settle();
    chk("R5 opposite edge ignored", {5'd0, irq_level}, 8'h00);
    irq_req_n[1] = 1'b1; settle();
    chk("R5 rising edge latched", {5'd0, irq_level}, 8'h04);
    wr(3'd1, 8'hDC); settle();
    chk("R6 clear pol1", {5'd0, irq_level}, 8'h00);

    // R6 clear has no effect in level mode
    wr(3'd6, 8'h13);
    irq_req_n[6] = 1'b0; settle();
    wr(3'd6, 8'h1B); settle();
    chk("R6 level clear no effect", {5'd0, irq_level}, 8'h03);
    irq_req_n[6] = 1'b1; settle();
    chk("R3 level release", {5'd0, irq_level}, 8'h00);

    // R7 captured while disabled, visible when enabled
    wr(3'd4, 8'h42);
    irq_req_n[4] = 1'b0; settle();
    chk("R7 disabled hides", {5'd0, irq_level}, 8'h00);
    irq_req_n[4] = 1'b1; settle();
    wr(3'd4, 8'h52); settle();
    chk("R7 enable reveals", {5'd0, irq_level}, 8'h02);
    wr(3'd4, 8'h5A); settle();
    chk("R6 clear again", {5'd0, irq_level}, 8'h00);

    // R10 edge and clear in the same cycle
    @(negedge clk); irq_req_n[4] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    reg_addr = 3'd4; reg_wdata = 8'h5A; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    settle();
    chk("R10 set wins", {5'd0, irq_level}, 8'h02);
    irq_req_n[4] = 1'b1;
    wr(3'd4, 8'h5A); settle();
    chk("R10 later clear works", {5'd0, irq_level}, 8'h00);

    finish_run();
  end
endmodule